// File: doc/BRIEF.md
# Interrupt Priority Store with Security-Aware Views

This block holds one 8-bit priority for each shared interrupt and gives software two access widths: single bytes, where the byte address is the interrupt number, and aligned 32-bit words that cover four neighbouring interrupts. Interrupt n sits in the least significant byte of a word, so word accesses are little-endian. Every access carries a secure attribute, and a global security-disable input turns the split between the two worlds off.

When security is enabled, a non-secure access cannot see the priority of an interrupt whose group bit is 0. Such a read returns zero and such a write is dropped. For a group-1 interrupt, a non-secure access works on a view that is compressed into the lower-priority half of the range. A write is shifted right and gets its top bit forced to one. A read is shifted left. Secure accesses, and every access while security is disabled, see raw values. Interrupts below 32 and at or above the implemented count have no storage. The stored priorities are exposed as one flat vector for the downstream selection logic. Each accepted write raises a one-cycle change strobe that names the range it touched.

Top module: `prio_bank`

## Requirements
- R1: After reset, every stored priority is zero and both `rdValid` and `chgValid` are low.
- R2: Interrupts below 32, and interrupts at or above `NUM_IRQ`, read as zero and never store a byte write.
- R3: With security enabled (`secDisable`=0), a non-secure access (`accSecure`=0) to an interrupt whose group bit is 0 reads as zero and leaves the stored priority unchanged.
- R4: A non-secure read of a group-1 interrupt with security enabled returns `(stored << 1) & 8'hFF`.
- R5: A non-secure write of value v to a group-1 interrupt with security enabled stores `8'h80 | (v >> 1)`.
- R6: A secure access, or any access while `secDisable`=1, reads and writes the raw stored byte.
- R7: A 32-bit read at address n returns interrupt n in bits 7:0, n+1 in 15:8, n+2 in 23:16 and n+3 in 31:24. Each lane is screened separately by R2 and R3.
- R8: A 32-bit write at address n puts data byte k into interrupt n+k. The whole write is dropped if n < 32 or n+3 ≥ `NUM_IRQ`. Otherwise each lane is screened separately by R3.
- R9: A 32-bit access with `accAddr[1:0]` ≠ 0 stores nothing and reads as zero.
- R10: A read accepted in cycle t gives `rdValid`=1 and its data on `rdData` in cycle t+1 (byte reads use bits 7:0, upper bits zero). `rdValid` is 0 in every other cycle.
- R11: If a write stores at least one byte, then in the following cycle `chgValid`=1, `chgFirst` holds the access address, and `chgCount` is 1 for a byte write or 4 for a word write. A write that stores nothing raises no strobe.
- R12: `prioVec[8i+7:8i]` shows the raw stored priority of interrupt i. Bytes for interrupts below 32 are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| accValid | input | 1 | Access request this cycle |
| accWrite | input | 1 | 1 for a write, 0 for a read |
| accWide | input | 1 | 1 for a 32-bit access, 0 for a byte access |
| accAddr | input | 10 | Byte offset in the priority window (equals the interrupt number) |
| accWdata | input | 32 | Write data; byte accesses use bits 7:0 |
| accSecure | input | 1 | Secure attribute of the access |
| secDisable | input | 1 | Global security disable |
| grpBits | input | NUM_IRQ | Group bit of each interrupt |
| rdValid | output | 1 | Read data valid |
| rdData | output | 32 | Read data |
| chgValid | output | 1 | One-cycle change strobe |
| chgFirst | output | 10 | First interrupt touched by the write |
| chgCount | output | 3 | Number of interrupts in the written range |
| prioVec | output | NUM_IRQ*8 | Raw priorities, 8 bits per interrupt |

## Verification
The bench aims at the edges of the shared range: bytes 31/32 and the last implemented interrupt, and word writes whose four lanes straddle either boundary. A design that checked only the first lane of a word would write past the end of the storage or into the reserved range. Mixed-group words written and read from the non-secure side expose any design that screens the group per word instead of per lane, or that applies the shift to the wrong direction of transfer. Misaligned words, writes that store nothing, and the change strobe are checked to catch strobes raised by dropped writes and reads that leak stale data.

// File: rtl/prio_bank_pkg.sv
package prio_bank_pkg;
  localparam int LANES        = 4;
  localparam int IRQ_W        = 10;
  localparam int SUM_W        = IRQ_W + 1;
  localparam int FIRST_SHARED = 32;

  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic [IRQ_W-1:0] baseIrq;
    logic [LANES-1:0] laneWe;
    logic [LANES-1:0] laneRe;
    logic             nsView;
    logic             rdEn;
  } prioStrobe_t;
endpackage

// File: rtl/prio_bank_ctrl.sv
module prio_bank_ctrl
  import prio_bank_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               accValid,
  input  logic               accWrite,
  input  logic               accWide,
  input  logic [IRQ_W-1:0]   accAddr,
  input  logic               accSecure,
  input  logic               secDisable,
  input  logic [NUM_IRQ-1:0] grpBits,
  output prioStrobe_t        stb,
  output logic               chgValid,
  output logic [IRQ_W-1:0]   chgFirst,
  output logic [2:0]         chgCount
);
  localparam logic [SUM_W-1:0] LO_IRQ = SUM_W'(FIRST_SHARED);
  localparam logic [SUM_W-1:0] HI_IRQ = SUM_W'(NUM_IRQ);

  function automatic logic grpOf(input logic [SUM_W-1:0] irq, input logic [NUM_IRQ-1:0] g);
    grpOf = 1'b0;
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (irq == SUM_W'(i)) grpOf = g[i];
    end
  endfunction

  logic [SUM_W-1:0] laneIrq [LANES];
  logic [LANES-1:0] inRange, grpOk, laneUsed;
  logic nsView, misaligned, rangeOk, isWr, isRd;

  assign nsView     = !accSecure && !secDisable;
  assign isWr       = accValid && accWrite;
  assign isRd       = accValid && !accWrite;
  assign misaligned = accWide && (accAddr[1:0] != 2'b00);

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign laneIrq[l]  = {1'b0, accAddr} + SUM_W'(l);
    assign inRange[l]  = (laneIrq[l] >= LO_IRQ) && (laneIrq[l] < HI_IRQ);
    assign grpOk[l]    = !nsView || grpOf(laneIrq[l], grpBits);
    assign laneUsed[l] = accWide || (l == 0);
  end

  // Word writes are range-checked as a whole; reads lane by lane
  assign rangeOk = accWide ? (inRange[0] && inRange[LANES-1]) : inRange[0];

  always_comb begin
    stb         = '0;
    stb.baseIrq = accAddr;
    stb.nsView  = nsView;
    stb.rdEn    = isRd;
    for (int l = 0; l < LANES; l++) begin
      stb.laneWe[l] = isWr && !misaligned && rangeOk && laneUsed[l] && grpOk[l];
      stb.laneRe[l] = isRd && !misaligned && laneUsed[l] && inRange[l] && grpOk[l];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      chgValid <= 1'b0;
      chgFirst <= '0;
      chgCount <= '0;
    end else begin
      chgValid <= |stb.laneWe;
      chgFirst <= accAddr;
      chgCount <= accWide ? 3'(LANES) : 3'd1;
    end
  end
endmodule

// File: rtl/prio_bank_dp.sv
module prio_bank_dp
  import prio_bank_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  prioStrobe_t          stb,
  input  logic [31:0]          accWdata,
  output logic                 rdValid,
  output logic [31:0]          rdData,
  output logic [NUM_IRQ*8-1:0] prioVec
);
  localparam int ENTRIES = NUM_IRQ - FIRST_SHARED;

  function automatic logic [7:0] wrView(input logic [7:0] v, input logic ns);
    wrView = ns ? {1'b1, v[7:1]} : v;
  endfunction

  function automatic logic [7:0] rdView(input logic [7:0] v, input logic ns);
    rdView = ns ? {v[6:0], 1'b0} : v;
  endfunction

  logic [ENTRIES*8-1:0] memFlat;
  logic [SUM_W-1:0]     entOffs [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    localparam logic [SUM_W-1:0] MY_IRQ = SUM_W'(e + FIRST_SHARED);
    logic [7:0] slot;
    assign entOffs[e] = MY_IRQ - {1'b0, stb.baseIrq};
    always_ff @(posedge clk) begin
      if (!rstN) begin
        slot <= '0;
      end else begin
        for (int l = 0; l < LANES; l++) begin
          if (stb.laneWe[l] && entOffs[e] == SUM_W'(l))
            slot <= wrView(accWdata[8*l +: 8], stb.nsView);
        end
      end
    end
    assign memFlat[8*e +: 8] = slot;
  end

  assign prioVec = {memFlat, {(FIRST_SHARED*8){1'b0}}};

  logic [31:0] rdNext;
  always_comb begin
    rdNext = '0;
    for (int l = 0; l < LANES; l++) begin
      for (int e = 0; e < ENTRIES; e++) begin
        if (stb.laneRe[l] && entOffs[e] == SUM_W'(l))
          rdNext[8*l +: 8] = rdView(memFlat[8*e +: 8], stb.nsView);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= stb.rdEn;
      rdData  <= rdNext;
    end
  end
endmodule

// File: rtl/prio_bank.sv
module prio_bank
  import prio_bank_pkg::*;
#(
  parameter int NUM_IRQ = 64
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 accValid,
  input  logic                 accWrite,
  input  logic                 accWide,
  input  logic [9:0]           accAddr,
  input  logic [31:0]          accWdata,
  input  logic                 accSecure,
  input  logic                 secDisable,
  input  logic [NUM_IRQ-1:0]   grpBits,
  output logic                 rdValid,
  output logic [31:0]          rdData,
  output logic                 chgValid,
  output logic [9:0]           chgFirst,
  output logic [2:0]           chgCount,
  output logic [NUM_IRQ*8-1:0] prioVec
);
  prioStrobe_t stb;

  prio_bank_ctrl #(.NUM_IRQ(NUM_IRQ)) i_ctrl (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accWide(accWide), .accAddr(accAddr), .accSecure(accSecure),
    .secDisable(secDisable), .grpBits(grpBits), .stb(stb),
    .chgValid(chgValid), .chgFirst(chgFirst), .chgCount(chgCount)
  );

  prio_bank_dp #(.NUM_IRQ(NUM_IRQ)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .accWdata(accWdata),
    .rdValid(rdValid), .rdData(rdData), .prioVec(prioVec)
  );
endmodule

// File: rtl/prio_bank_chk.sv
module prio_bank_chk #(
  parameter int NUM_IRQ = 64
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 accValid,
  input logic                 accWrite,
  input logic                 accWide,
  input logic [9:0]           accAddr,
  input logic                 accSecure,
  input logic                 secDisable,
  input logic                 rdValid,
  input logic [31:0]          rdData,
  input logic                 chgValid,
  input logic [9:0]           chgFirst,
  input logic [2:0]           chgCount,
  input logic [NUM_IRQ*8-1:0] prioVec
);
  logic [NUM_IRQ*8-1:0] shifted;
  assign shifted = prioVec >> {chgFirst, 3'd0};

  AST_RD_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite) |=> rdValid);  // R10
  AST_RD_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (!rstN)
    !(accValid && !accWrite) |=> !rdValid);  // R10
  AST_MISALIGNED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !accWrite && accWide && accAddr[1:0] != 2'b00) |=> (rdData == 32'd0));  // R9
  AST_CHG_AFTER_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    chgValid |-> ($past(accValid && accWrite) && chgFirst == $past(accAddr)));  // R11
  AST_CHG_COUNT: assert property (@(posedge clk) disable iff (!rstN)
    chgValid |-> (chgCount == 3'd1 || chgCount == 3'd4));  // R11
  AST_CHG_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    chgValid |-> (chgFirst >= 10'd32 && 32'(chgFirst) + 32'(chgCount) <= NUM_IRQ));  // R2
  AST_NS_TOP_BIT: assert property (@(posedge clk) disable iff (!rstN)
    (chgValid && chgCount == 3'd1 && $past(!accSecure && !secDisable)) |-> shifted[7]);  // R5
endmodule

bind prio_bank prio_bank_chk #(.NUM_IRQ(NUM_IRQ)) i_chk (
  .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
  .accWide(accWide), .accAddr(accAddr), .accSecure(accSecure),
  .secDisable(secDisable), .rdValid(rdValid), .rdData(rdData),
  .chgValid(chgValid), .chgFirst(chgFirst), .chgCount(chgCount),
  .prioVec(prioVec)
);

// File: tb/test_prio_bank.sv
`timescale 1ns/1ps
module test_prio_bank;
  localparam int NIRQ = 64;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rstN, accValid, accWrite, accWide, accSecure, secDisable;
  logic [9:0] accAddr;
  logic [31:0] accWdata, rdData;
  logic [NIRQ-1:0] grpBits;
  logic rdValid, chgValid;
  logic [9:0] chgFirst;
  logic [2:0] chgCount;
  logic [NIRQ*8-1:0] prioVec;

  prio_bank #(.NUM_IRQ(NIRQ)) i_prio_bank (
    .clk(clk), .rstN(rstN), .accValid(accValid), .accWrite(accWrite),
    .accWide(accWide), .accAddr(accAddr), .accWdata(accWdata),
    .accSecure(accSecure), .secDisable(secDisable), .grpBits(grpBits),
    .rdValid(rdValid), .rdData(rdData), .chgValid(chgValid),
    .chgFirst(chgFirst), .chgCount(chgCount), .prioVec(prioVec)
  );

  logic [7:0] mdl [NIRQ];
  int checks = 0;
  int fails = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mRd(input int irq, input bit sec);
    bit ns = !sec && !secDisable;
    if (irq < 32 || irq >= NIRQ) return 8'h00;
    if (ns && !grpBits[irq]) return 8'h00;
    return ns ? {mdl[irq][6:0], 1'b0} : mdl[irq];
  endfunction

  function automatic bit mCanWr(input int irq, input bit sec);
    bit ns = !sec && !secDisable;
    if (irq < 32 || irq >= NIRQ) return 1'b0;
    return !(ns && !grpBits[irq]);
  endfunction

  function automatic logic [7:0] mWrVal(input logic [7:0] v, input bit sec);
    return (!sec && !secDisable) ? {1'b1, v[7:1]} : v;
  endfunction

  task automatic op(input bit wr, input bit wide, input int addr, input logic [31:0] wd,
                    input bit sec, input string tag);
    logic [31:0] expRd = '0;
    bit expChg = 1'b0;
    bit mis = wide && (addr % 4 != 0);
    if (!wr && !mis) begin
      if (wide) for (int k = 0; k < 4; k++) expRd[8*k +: 8] = mRd(addr + k, sec);
      else expRd[7:0] = mRd(addr, sec);
    end
    @(negedge clk);
    accValid = 1'b1; accWrite = wr; accWide = wide; accAddr = 10'(addr);
    accWdata = wd; accSecure = sec;
    @(negedge clk);
    accValid = 1'b0;
    if (wr && !mis) begin
      if (wide) begin
        if (addr >= 32 && addr + 3 < NIRQ)
          for (int k = 0; k < 4; k++)
            if (mCanWr(addr + k, sec)) begin
              mdl[addr + k] = mWrVal(wd[8*k +: 8], sec);
              expChg = 1'b1;
            end
      end else if (mCanWr(addr, sec)) begin
        mdl[addr] = mWrVal(wd[7:0], sec);
        expChg = 1'b1;
      end
    end
    chk({tag, " R10 rdValid"}, 64'(rdValid), 64'(!wr));
    if (!wr) chk({tag, " rdData"}, 64'(rdData), 64'(expRd));
    chk({tag, " R11 chgValid"}, 64'(chgValid), 64'(expChg));
    if (expChg) begin
      chk("R11 chgFirst", 64'(chgFirst), 64'(addr));
      chk("R11 chgCount", 64'(chgCount), wide ? 64'd4 : 64'd1);
    end
  endtask

  task automatic chkVec();
    for (int i = 0; i < NIRQ; i++)
      chk("R12 prioVec", 64'(prioVec[8*i +: 8]), (i < 32) ? 64'd0 : 64'(mdl[i]));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; accValid = 1'b0; accWrite = 1'b0; accWide = 1'b0;
    accAddr = '0; accWdata = '0; accSecure = 1'b0; secDisable = 1'b0;
    grpBits = {32'hAAAA_AAAA, 32'h0};
    for (int i = 0; i < NIRQ; i++) mdl[i] = 8'h00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    chk("R1 rdValid", 64'(rdValid), 0);
    chk("R1 chgValid", 64'(chgValid), 0);
    chk("R1 prioVec", 64'(|prioVec), 0);

    // Directed corner cases
    op(1, 0, 40, 32'h5A, 1, "R6 sec wr");
    op(0, 0, 40, 0, 1, "R6 sec rd");
    op(0, 0, 40, 0, 0, "R3 ns rd grp0");
    op(1, 0, 40, 32'hFF, 0, "R3 ns wr grp0");
    op(0, 0, 40, 0, 1, "R3 after ignored wr");
    op(1, 0, 41, 32'h64, 0, "R5 ns wr grp1");
    op(0, 0, 41, 0, 1, "R5 sec rd back");
    op(0, 0, 41, 0, 0, "R4 ns rd grp1");
    op(1, 0, 31, 32'h77, 1, "R2 wr below 32");
    op(0, 0, 31, 0, 1, "R2 rd below 32");
    op(1, 0, 64, 32'h77, 1, "R2 wr past end");
    op(1, 0, 32, 32'h11, 1, "R2 first shared");
    op(1, 0, 63, 32'h22, 1, "R2 last shared");
    op(1, 1, 44, 32'h4433_2211, 1, "R8 word wr");
    op(0, 1, 44, 0, 1, "R7 word rd");
    op(1, 1, 48, 32'hF0E0_D0C0, 0, "R8 ns mixed-group word");
    op(0, 1, 48, 0, 0, "R7 ns mixed-group rd");
    op(1, 1, 60, 32'hDEAD_BEEF, 1, "R8 last word");
    op(1, 1, 28, 32'h1234_5678, 1, "R8 word below 32");
    op(0, 1, 28, 0, 1, "R7 word rd straddle low");
    op(1, 1, 64, 32'h1234_5678, 1, "R8 word past end");
    op(1, 1, 46, 32'h9999_9999, 1, "R9 misaligned wr");
    op(0, 1, 45, 0, 1, "R9 misaligned rd");
    secDisable = 1'b1;
    op(0, 0, 40, 0, 0, "R6 ns rd sec disabled");
    op(1, 0, 42, 32'h33, 0, "R6 ns wr sec disabled");
    op(0, 1, 40, 0, 0, "R6 word rd sec disabled");
    secDisable = 1'b0;
    chkVec();

    // Constrained random mix
    for (int n = 0; n < 800; n++) begin
      int a;
      bit w, wd, s;
      if (n % 64 == 63) begin
        secDisable = ($urandom % 4 == 0);
        grpBits = {$urandom, 32'h0};
      end
      a  = ($urandom % 8 == 0) ? int'($urandom % 1024) : 24 + int'($urandom % 48);
      wd = $urandom % 2;
      if (wd && ($urandom % 4 != 0)) a = a & ~3;
      w = $urandom % 2;
      s = $urandom % 2;
      op(w, wd, a, $urandom, s, w ? "R5 R8 rand wr" : "R4 R6 R7 rand rd");
      if (n % 100 == 99) chkVec();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule